// File: doc/BRIEF.md
# Dual-master split-bus arbiter

This block arbitrates a pipelined processor bus whose address and data phases are separate tenures, shared by two bus masters. Each master has its own bus request, its own address grant and its own data grant. All other bus signals are shared. The arbiter watches the following shared signals:

- transfer start and extended-address transfer start
- address acknowledge and address retry
- data-bus-busy and transfer acknowledge

Address grants are handed out round-robin. Every address tenure the bus accepts is recorded in a small ordered queue. The data grants then follow the queue order, so a second address phase can overlap the first data phase.

An accepted tenure holds its data grant back until its retry window has passed. The retry window is the cycle after address acknowledge. If retry is seen in that window, the tenure is dropped. An earlier tenure already in the queue is not affected. A data grant is also held back while the data bus is busy or another data tenure is running.

A data tenure ends on its final transfer acknowledge. That is the first beat for a single transfer and the last beat for a burst.

Extended-address transfers are not supported. When error reporting is enabled, the data tenure of such a transfer is ended with a one-cycle transfer error and no transfer acknowledge.

Top module: `split_bus_arbiter`

## Requirements
- R1: While rst_ni is low and after reset, agnt_o, dgnt_o and tea_o are all zero; the round-robin pointer favours master 0.
- R2: agnt_o is registered: it rises one clock after a request is seen, only when no address tenure is open, no retry window is pending and fewer than DEPTH tenures are queued. It is one-hot (bit m is master m). It drops the clock after ts_i or xts_i is sampled with it.
- R3: When req_i is 2'b11 the grant goes to the master the pointer favours, and the pointer then moves to the other master. A lone requester is always granted.
- R4: A queued tenure may receive a data grant no earlier than the cycle after its retry window. dgnt_o is never asserted while dbusy_i is high or a data tenure is running.
- R5: Data grants are issued in the order in which address tenures were acknowledged, with dgnt_o bit m granting master m.
- R6: retry_i high in the cycle after aack_i removes only that newest tenure from the queue, which then never receives a data grant. Older queued tenures keep their grant.
- R7: A data tenure begins in the cycle after dgnt_o is seen. For a tenure started with burst_i low it ends on the first ta_i. For burst_i high it ends on the BEATS-th ta_i (4 by default). The next data grant may appear in the cycle after the final ta_i.
- R8: With DEPTH (2) tenures queued, no address grant is issued even while requests are held.
- R9: A tenure started with xts_i while err_en_i is high ends its data tenure with tea_o high for exactly the one cycle after its data grant, needing no ta_i. With err_en_i low it completes on ta_i like any single transfer and tea_o stays low.
- R10: An address grant whose master drops its request before transfer start is withdrawn on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Bus request, bit m from master m |
| ts_i | input | 1 | Transfer start of the granted master |
| xts_i | input | 1 | Extended-address transfer start |
| burst_i | input | 1 | Burst transfer, sampled with transfer start |
| aack_i | input | 1 | Address acknowledge, closes the address tenure |
| retry_i | input | 1 | Address retry, meaningful in the cycle after aack_i |
| dbusy_i | input | 1 | Data bus busy |
| ta_i | input | 1 | Transfer acknowledge, one per data beat |
| err_en_i | input | 1 | Enables transfer error for extended-address transfers |
| agnt_o | output | 2 | Address bus grant, bit m to master m |
| dgnt_o | output | 2 | Data bus grant, bit m to master m |
| tea_o | output | 1 | Transfer error acknowledge |

## Verification
The stimulus patterns each isolate one behaviour:

- A lone single transfer shows the one-cycle registered address grant and the data grant held back through the retry window.
- Simultaneous and withdrawn requests separate true round-robin from fixed priority.
- A burst from master 1 queued ahead of a single from master 0, with the data bus held busy, shows both the grant order and the fourth-beat termination. It also shows that a full queue stalls address grants.
- A retried second tenure behind a confirmed one shows that retry removes only its own tenure.
- Extended-address starts with error reporting on and off show the difference between error termination and normal acknowledge termination.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef struct packed {
    logic mst;  // owning master
    logic bst;  // burst tenure
    logic err;  // end with transfer error
    logic ok;   // retry window passed
  } ten_t;
endpackage

// File: rtl/sba_addr_arb.sv
module sba_addr_arb
  import sba_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       ts_i,
  input  logic       xts_i,
  input  logic       burst_i,
  input  logic       aack_i,
  input  logic       err_en_i,
  input  logic       space_i,
  output logic [1:0] agnt_o,
  output logic       push_o,
  output ten_t       push_d_o,
  output logic       win_o
);
  logic [1:0] agnt_q;
  logic       rr_q, ten_q, win_q, own_q, bst_q, err_q;
  logic       start, idle, pick;

  assign start = (|agnt_q) && (ts_i || xts_i);
  assign idle  = !ten_q && !win_q && (agnt_q == 2'b00);
  assign pick  = (req_i == 2'b11) ? rr_q : req_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agnt_q <= 2'b00;
      rr_q   <= 1'b0;
      ten_q  <= 1'b0;
      win_q  <= 1'b0;
      own_q  <= 1'b0;
      bst_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      win_q <= ten_q && aack_i;
      if (ten_q && aack_i) ten_q <= 1'b0;
      if (|agnt_q) begin
        if (start) begin
          ten_q  <= 1'b1;
          own_q  <= agnt_q[1];
          bst_q  <= burst_i;
          err_q  <= xts_i && err_en_i;
          agnt_q <= 2'b00;
        end else if (!(|(req_i & agnt_q))) begin
          agnt_q <= 2'b00;
        end
      end else if (idle && space_i && (|req_i)) begin
        agnt_q <= pick ? 2'b10 : 2'b01;
        rr_q   <= !pick;
      end
    end
  end

  assign agnt_o       = agnt_q;
  assign push_o       = ten_q && aack_i;
  assign push_d_o.mst = own_q;
  assign push_d_o.bst = bst_q;
  assign push_d_o.err = err_q;
  assign push_d_o.ok  = 1'b0;
  assign win_o        = win_q;
endmodule

// File: rtl/sba_order_fifo.sv
module sba_order_fifo
  import sba_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  ten_t push_d_i,
  input  logic win_i,
  input  logic retry_i,
  input  logic pop_i,
  output logic hv_o,
  output ten_t head_o,
  output logic space_o
);
  localparam int CW = $clog2(DEPTH + 1);

  ten_t          e_q [DEPTH];
  ten_t          e_n [DEPTH];
  logic [CW-1:0] cnt_q, c;

  always_comb begin
    e_n = e_q;
    c   = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) e_n[i] = e_q[i+1];
      e_n[DEPTH-1] = '0;
      c = c - CW'(1);
    end
    // retry window always concerns the newest entry
    if (win_i) begin
      if (retry_i) begin
        c = c - CW'(1);
        for (int i = 0; i < DEPTH; i++) if (CW'(i) == c) e_n[i] = '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) if (CW'(i) == c - CW'(1)) e_n[i].ok = 1'b1;
      end
    end
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) if (CW'(i) == c) e_n[i] = push_d_i;
      c = c + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) e_q[i] <= '0;
    end else begin
      cnt_q <= c;
      for (int i = 0; i < DEPTH; i++) e_q[i] <= e_n[i];
    end
  end

  assign hv_o    = cnt_q != '0;
  assign head_o  = e_q[0];
  assign space_o = cnt_q < CW'(DEPTH);
endmodule

// File: rtl/sba_data_seq.sv
module sba_data_seq
  import sba_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hv_i,
  input  ten_t       head_i,
  input  logic       dbusy_i,
  input  logic       ta_i,
  output logic [1:0] dgnt_o,
  output logic       tea_o,
  output logic       pop_o
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic          act_q, tea_q, gnt_ok;
  logic [BW-1:0] beat_q, last;

  assign last   = head_i.bst ? BW'(BEATS - 1) : '0;
  assign gnt_ok = !act_q && hv_i && head_i.ok && !dbusy_i;
  assign dgnt_o = gnt_ok ? (head_i.mst ? 2'b10 : 2'b01) : 2'b00;
  assign pop_o  = act_q && (head_i.err || (ta_i && (beat_q == last)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      tea_q  <= 1'b0;
      beat_q <= '0;
    end else if (gnt_ok) begin
      act_q  <= 1'b1;
      beat_q <= '0;
      tea_q  <= head_i.err;
    end else if (act_q) begin
      if (pop_o) begin
        act_q <= 1'b0;
        tea_q <= 1'b0;
      end else if (ta_i) begin
        beat_q <= beat_q + BW'(1);
      end
    end
  end

  assign tea_o = tea_q;
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter
  import sba_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int BEATS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       ts_i,
  input  logic       xts_i,
  input  logic       burst_i,
  input  logic       aack_i,
  input  logic       retry_i,
  input  logic       dbusy_i,
  input  logic       ta_i,
  input  logic       err_en_i,
  output logic [1:0] agnt_o,
  output logic [1:0] dgnt_o,
  output logic       tea_o
);
  logic push, win, pop, hv, fifo_space;
  ten_t push_d, head;

  sba_addr_arb i_addr (
    .clk_i, .rst_ni, .req_i, .ts_i, .xts_i, .burst_i, .aack_i, .err_en_i,
    .space_i (fifo_space),
    .agnt_o,
    .push_o  (push),
    .push_d_o(push_d),
    .win_o   (win)
  );

  sba_order_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .push_d_i(push_d),
    .win_i   (win),
    .retry_i,
    .pop_i   (pop),
    .hv_o    (hv),
    .head_o  (head),
    .space_o (fifo_space)
  );

  sba_data_seq #(.BEATS(BEATS)) i_data (
    .clk_i, .rst_ni,
    .hv_i  (hv),
    .head_i(head),
    .dbusy_i, .ta_i,
    .dgnt_o, .tea_o,
    .pop_o (pop)
  );
endmodule

// File: rtl/sba_chk.sv
module sba_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_i,
  input logic       ts_i,
  input logic       xts_i,
  input logic       dbusy_i,
  input logic [1:0] agnt_o,
  input logic [1:0] dgnt_o,
  input logic       tea_o,
  input logic       fifo_space
);
  // R2
  agnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(agnt_o));
  // R5
  dgnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dgnt_o));
  // R4
  dgnt_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dgnt_o) |-> !dbusy_i);
  // R7
  dgnt_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dgnt_o) |=> (dgnt_o == 2'b00));
  // R8
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_space && (agnt_o == 2'b00)) |=> (agnt_o == 2'b00));
  // R2
  agnt_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|agnt_o) && (ts_i || xts_i)) |=> (agnt_o == 2'b00));
  // R10
  agnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|agnt_o) && !ts_i && !xts_i && (|(req_i & agnt_o))) |=> $stable(agnt_o));
  // R9
  tea_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_o |=> !tea_o);
  // R9
  tea_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_o |-> $past(|dgnt_o));
endmodule

bind split_bus_arbiter sba_chk i_chk (
  .clk_i, .rst_ni, .req_i, .ts_i, .xts_i, .dbusy_i,
  .agnt_o, .dgnt_o, .tea_o, .fifo_space
);

// File: tb/test_split_bus_arbiter.sv
module test_split_bus_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] req_i = '0;
  logic       ts_i = 0, xts_i = 0, burst_i = 0, aack_i = 0, retry_i = 0;
  logic       dbusy_i = 0, ta_i = 0, err_en_i = 0;
  logic [1:0] agnt_o, dgnt_o;
  logic       tea_o;
  int nchk = 0;
  int nfail = 0;

  always #5 clk_i = ~clk_i;

  split_bus_arbiter i_split_bus_arbiter (.*);

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // request, start, acknowledge and retry window for one address tenure
  task automatic addr_tenure(input int m, input bit bst, input bit x, input bit rty);
    bit got = 0;
    req_i[m] = 1'b1;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk_i); #1;
      got = agnt_o[m];
    end
    chk("R2 grant reached", {3'b0, got}, 4'h1);
    if (x) xts_i = 1'b1; else ts_i = 1'b1;
    burst_i = bst;
    req_i[m] = 1'b0;
    @(negedge clk_i); ts_i = 0; xts_i = 0; burst_i = 0; aack_i = 1;
    @(negedge clk_i); aack_i = 0; retry_i = rty;
    @(negedge clk_i); retry_i = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 agnt in reset", {2'b0, agnt_o}, 4'h0);
    chk("R1 dgnt in reset", {2'b0, dgnt_o}, 4'h0);
    chk("R1 tea in reset", {3'b0, tea_o}, 4'h0);
  endtask

  task automatic t_single();
    @(negedge clk_i); req_i = 2'b01; #1;
    chk("R2 no grant same cycle", {2'b0, agnt_o}, 4'h0);
    @(negedge clk_i); #1;
    chk("R2 grant master0", {2'b0, agnt_o}, 4'h1);
    ts_i = 1; req_i = 2'b00;
    @(negedge clk_i); #1;
    chk("R2 grant drops after start", {2'b0, agnt_o}, 4'h0);
    ts_i = 0; aack_i = 1;
    @(negedge clk_i); aack_i = 0; #1;
    chk("R4 no dgnt in retry window", {2'b0, dgnt_o}, 4'h0);
    @(negedge clk_i); #1;
    chk("R4 dgnt after window", {2'b0, dgnt_o}, 4'h1);
    @(negedge clk_i); #1;
    chk("R4 no dgnt during tenure", {2'b0, dgnt_o}, 4'h0);
    ta_i = 1;
    @(negedge clk_i); ta_i = 0; #1;
    chk("R7 single ends, queue empty", {2'b0, dgnt_o}, 4'h0);
  endtask

  task automatic t_round_robin();
    // pointer favours master 1 after master 0 was granted
    @(negedge clk_i); req_i = 2'b11;
    @(negedge clk_i); #1;
    chk("R3 both request, master1", {2'b0, agnt_o}, 4'h2);
    req_i = 2'b00;
    @(negedge clk_i); #1;
    chk("R10 grant withdrawn", {2'b0, agnt_o}, 4'h0);
    req_i = 2'b11;
    @(negedge clk_i); #1;
    chk("R3 alternates to master0", {2'b0, agnt_o}, 4'h1);
    req_i = 2'b00;
    @(negedge clk_i); req_i = 2'b11;
    @(negedge clk_i); #1;
    chk("R3 alternates to master1", {2'b0, agnt_o}, 4'h2);
    req_i = 2'b00;
    @(negedge clk_i); req_i = 2'b10;
    @(negedge clk_i); #1;
    chk("R3 lone requester master1", {2'b0, agnt_o}, 4'h2);
    req_i = 2'b00;
    @(negedge clk_i);
  endtask

  task automatic t_pipeline();
    dbusy_i = 1;
    addr_tenure(1, 1'b1, 1'b0, 1'b0);
    #1 chk("R4 busy holds dgnt", {2'b0, dgnt_o}, 4'h0);
    addr_tenure(0, 1'b0, 1'b0, 1'b0);
    req_i = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #1;
      chk("R8 queue full, no agnt", {2'b0, agnt_o}, 4'h0);
    end
    req_i = 2'b00;
    @(negedge clk_i); dbusy_i = 0; #1;
    chk("R5 first dgnt to master1", {2'b0, dgnt_o}, 4'h2);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk_i); ta_i = 1; #1;
      chk("R7 burst beat, no dgnt", {2'b0, dgnt_o}, 4'h0);
    end
    @(negedge clk_i); ta_i = 0; #1;
    chk("R5 R7 next dgnt to master0 after fourth beat", {2'b0, dgnt_o}, 4'h1);
    @(negedge clk_i); ta_i = 1;
    @(negedge clk_i); ta_i = 0;
  endtask

  task automatic t_retry();
    dbusy_i = 1;
    addr_tenure(1, 1'b0, 1'b0, 1'b0);
    addr_tenure(0, 1'b0, 1'b0, 1'b1);
    dbusy_i = 0; #1;
    chk("R6 older tenure keeps dgnt", {2'b0, dgnt_o}, 4'h2);
    @(negedge clk_i); ta_i = 1;
    @(negedge clk_i); ta_i = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #1;
      chk("R6 retried tenure never granted", {2'b0, dgnt_o}, 4'h0);
    end
    req_i = 2'b01;
    @(negedge clk_i); #1;
    chk("R6 queue slot freed, agnt", {2'b0, agnt_o}, 4'h1);
    req_i = 2'b00;
    @(negedge clk_i);
  endtask

  task automatic t_ext_err();
    dbusy_i = 1; err_en_i = 1;
    addr_tenure(0, 1'b0, 1'b1, 1'b0);
    addr_tenure(1, 1'b0, 1'b0, 1'b0);
    dbusy_i = 0; #1;
    chk("R9 dgnt to extended tenure", {2'b0, dgnt_o}, 4'h1);
    @(negedge clk_i); #1;
    chk("R9 tea pulse", {3'b0, tea_o}, 4'h1);
    @(negedge clk_i); #1;
    chk("R9 tea one cycle", {3'b0, tea_o}, 4'h0);
    chk("R9 ended without ta", {2'b0, dgnt_o}, 4'h2);
    @(negedge clk_i); ta_i = 1;
    @(negedge clk_i); ta_i = 0;
    err_en_i = 0;
    addr_tenure(0, 1'b0, 1'b1, 1'b0);
    #1 chk("R9 dgnt, reporting off", {2'b0, dgnt_o}, 4'h1);
    @(negedge clk_i); #1;
    chk("R9 no tea when disabled", {3'b0, tea_o}, 4'h0);
    @(negedge clk_i); #1;
    chk("R9 waits for ta", {3'b0, tea_o}, 4'h0);
    ta_i = 1;
    @(negedge clk_i); ta_i = 0;
    req_i = 2'b10;
    @(negedge clk_i); #1;
    chk("R9 tenure ended on ta", {2'b0, agnt_o}, 4'h2);
    req_i = 2'b00;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_round_robin();
    t_pipeline();
    t_retry();
    t_ext_err();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule